// File: doc/BRIEF.md
# Multifunction Arithmetic/Logic Unit with Barrel Shifter

A purely combinational 32-bit datapath element that computes one result per control word. Three engines run in parallel on the same operands: an adder/subtractor, a bitwise logic unit and a multistage barrel shifter. A two-bit class field picks which engine drives the result. A fourth class returns a one-bit signed "less than" comparison that is taken from the adder.

The block has no clock, no state and no handshake. A surrounding pipeline presents `opa`, `opb`, a constant shift amount and the 8-bit control word, and then captures `result`, `zero` and `ovf` in the same cycle. The shifter always moves `opb`. A variable shift amount is taken from the low five bits of `opa`.

The control word has these fields: `ctl[7:6]` is the class, `ctl[5]` is subtract, `ctl[4]` selects a variable shift amount, `ctl[3:2]` is the shift kind and `ctl[1:0]` is the logic function.

Top module: `alu_multifn`

## Requirements
- R1: `ctl[7:6]` selects the result source: 00 shifter, 01 set-less-than, 10 adder/subtractor, 11 logic unit.
- R2: With class 10 and `ctl[5]`=0, `result` equals `opa + opb` modulo 2^32.
- R3: With class 10 and `ctl[5]`=1, `result` equals `opa - opb` modulo 2^32, computed as `opa + ~opb + 1`.
- R4: `ovf` is 1 only in class 10 and only when the signed two's-complement sum or difference does not fit in 32 bits. In every other class it is 0.
- R5: In class 11, `ctl[1:0]` selects 00 AND, 01 OR, 10 XOR, 11 NOR of `opa` and `opb`.
- R6: In class 00, `ctl[3:2]` selects 00 pass `opb` unchanged, 01 logical left shift, 10 logical right shift, 11 arithmetic right shift of `opb`. Logical shifts fill vacated bits with 0.
- R7: An arithmetic right shift copies bit 31 of `opb` into every vacated position.
- R8: `ctl[4]`=0 takes the shift amount from `shamt`, and `ctl[4]`=1 takes it from `opa[4:0]`. Bits 31..5 of `opa` have no effect on the shift.
- R9: In class 01, `result` is 1 when `opa` is less than `opb` as signed numbers, including operand pairs whose difference overflows, and 0 otherwise. The block always subtracts in this class, whatever `ctl[5]` holds.
- R10: `zero` is 1 exactly when all 32 bits of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand; its low 5 bits supply the variable shift amount |
| opb | input | 32 | Second operand; this is the value the shifter moves |
| shamt | input | 5 | Constant shift amount |
| ctl | input | 8 | Control word: class, subtract, amount source, shift kind, logic function |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of the add/subtract class |

## Verification
The block holds no state, so a fault in the carry chain, in one shifter stage or in the class select shows up in `result` or the flags in the same cycle as the operands that expose it. A broken shifter stage corrupts only the amounts that have that stage's bit set. A wrong carry corrupts only operands whose carries reach that position. Because of this, the stimulus sweeps random operands and amounts over every class and shift kind. It also applies directed edges: the sign boundary, all-ones and zero operands, a shift by 31, and overflowing comparisons.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    CL_SHIFT = 2'b00,
    CL_SLT   = 2'b01,
    CL_ARITH = 2'b10,
    CL_LOGIC = 2'b11
  } alu_class_e;

  typedef enum logic [1:0] {
    SK_NONE = 2'b00,
    SK_SLL  = 2'b01,
    SK_SRL  = 2'b10,
    SK_SRA  = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    LF_AND = 2'b00,
    LF_OR  = 2'b01,
    LF_XOR = 2'b10,
    LF_NOR = 2'b11
  } logic_fn_e;

  typedef struct packed {
    alu_class_e  cls;
    logic        sub;
    logic        var_amt;
    shift_kind_e sk;
    logic_fn_e   lf;
  } alu_ctl_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] bx, g, p;
  logic [W:0]   carry;

  assign bx = b ^ {W{sub}};
  assign g  = a & bx;
  assign p  = a ^ bx;

  always_comb begin
    carry[0] = sub;
    for (int i = 0; i < int'(W); i++) begin
      carry[i+1] = g[i] | (p[i] & carry[i]);
    end
  end

  assign sum = p ^ carry[W-1:0];
  assign ovf = carry[W] ^ carry[W-1];

  always_comb begin
    if (!sub) begin
      assert_add_R2: assert (sum == W'(a + b)) else $error("adder sum wrong");
    end else begin
      assert_sub_R3: assert (sum == W'(a - b)) else $error("subtract wrong");
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res
);
  logic [SW:0][W-1:0] st;
  logic [SW-1:0]      amt_eff;
  logic               fill, left;

  assign amt_eff = (kind == SK_NONE) ? '0 : amt;
  assign fill    = (kind == SK_SRA) & val[W-1];
  assign left    = (kind == SK_SLL);
  assign st[0]   = val;

  for (genvar i = 0; i < int'(SW); i++) begin : g_stage
    localparam int unsigned S = 1 << i;
    assign st[i+1] = !amt_eff[i] ? st[i] :
                     left ? {st[i][W-1-S:0], {S{1'b0}}} :
                            {{S{fill}}, st[i][W-1:S]};
  end

  assign res = st[SW];

  always_comb begin
    if (kind == SK_NONE) begin
      assert_pass_R6: assert (res == val) else $error("no-shift altered value");
    end
    if (kind == SK_SRA) begin
      assert_sign_R7: assert (res[W-1] == val[W-1]) else $error("sign lost");
    end
    if (kind == SK_SRL && amt != '0) begin
      assert_zfill_R6: assert (res[W-1] == 1'b0) else $error("srl fill not zero");
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (fn)
      LF_AND:  res = a & b;
      LF_OR:   res = a | b;
      LF_XOR:  res = a ^ b;
      default: res = ~(a | b);
    endcase
  end

  always_comb begin
    if (fn == LF_XOR) begin
      assert_xor_R5: assert ((res ^ b) == a) else $error("xor not invertible");
    end
    if (fn == LF_NOR) begin
      assert_nor_R5: assert ((res & (a | b)) == '0) else $error("nor overlaps inputs");
    end
  end
endmodule

// File: rtl/alu_multifn.sv
module alu_multifn
  import alu_pkg::*;
#(
  parameter int unsigned W  = DW,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [SW-1:0] shamt,
  input  logic [7:0]    ctl,
  output logic [W-1:0]  result,
  output logic          zero,
  output logic          ovf
);
  alu_ctl_t      c;
  logic          sub_eff, add_ovf, lt;
  logic [W-1:0]  sum, shres, lres;
  logic [SW-1:0] amt;

  assign c       = alu_ctl_t'(ctl);
  assign sub_eff = c.sub | (c.cls == CL_SLT);
  assign amt     = c.var_amt ? opa[SW-1:0] : shamt;

  alu_addsub #(.W(W)) u_add (
    .a(opa), .b(opb), .sub(sub_eff), .sum(sum), .ovf(add_ovf)
  );

  alu_shifter #(.W(W)) u_shf (
    .val(opb), .amt(amt), .kind(c.sk), .res(shres)
  );

  alu_logic #(.W(W)) u_log (
    .a(opa), .b(opb), .fn(c.lf), .res(lres)
  );

  assign lt = sum[W-1] ^ add_ovf;

  always_comb begin
    unique case (c.cls)
      CL_SHIFT: result = shres;
      CL_SLT:   result = {{(W-1){1'b0}}, lt};
      CL_ARITH: result = sum;
      default:  result = lres;
    endcase
  end

  assign zero = ~|result;
  assign ovf  = (c.cls == CL_ARITH) & add_ovf;

  always_comb begin
    if (ovf) begin
      assert_ovf_class_R4: assert (c.cls == CL_ARITH) else $error("ovf outside arith");
    end
    if (c.cls == CL_SLT) begin
      assert_slt_width_R9: assert ($countones(result[W-1:1]) == 0) else $error("slt wide");
    end
    if (c.cls == CL_ARITH) begin
      assert_arith_sel_R1: assert (result == sum) else $error("arith select");
    end
  end
endmodule

// File: tb/sim_alu_multifn.sv
`timescale 1ns/1ps
module sim_alu_multifn;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa, opb, result;
  logic [4:0]  shamt;
  logic [7:0]  ctl;
  logic        zero, ovf;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu_multifn u0 (
    .opa(opa), .opb(opb), .shamt(shamt), .ctl(ctl),
    .result(result), .zero(zero), .ovf(ovf)
  );

  function automatic logic [7:0] mk(input logic [1:0] cl, input logic s,
                                    input logic v, input logic [1:0] k,
                                    input logic [1:0] lf);
    return {cl, s, v, k, lf};
  endfunction

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [4:0] k, input logic [7:0] c);
    logic [1:0]  cl;
    logic        s, ov;
    longint      r;
    logic [4:0]  n;
    logic [31:0] res;
    cl = c[7:6];
    s  = c[5] | (cl == 2'b01);
    r  = s ? (longint'($signed(a)) - longint'($signed(b)))
           : (longint'($signed(a)) + longint'($signed(b)));
    ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    n  = c[4] ? a[4:0] : k;
    case (cl)
      2'b00: case (c[3:2])
               2'b00: res = b;
               2'b01: res = b << n;
               2'b10: res = b >> n;
               default: res = $unsigned($signed(b) >>> n);
             endcase
      2'b01: res = {31'b0, $signed(a) < $signed(b)};
      2'b10: res = c[5] ? a - b : a + b;
      default: case (c[1:0])
               2'b00: res = a & b;
               2'b01: res = a | b;
               2'b10: res = a ^ b;
               default: res = ~(a | b);
             endcase
    endcase
    return {(cl == 2'b10) & ov, res};
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    case (c[7:6])
      2'b00: return (c[3:2] == 2'b11) ? "R7" : (c[4] ? "R8" : "R6");
      2'b01: return "R9";
      2'b10: return c[5] ? "R3" : "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] k, input logic [7:0] c, input string tag);
    logic [32:0] e;
    @(posedge clk);
    opa = a; opb = b; shamt = k; ctl = c;
    @(negedge clk);
    e = model(a, b, k, c);
    n_chk++;
    if (result !== e[31:0] || ovf !== e[32] || zero !== (e[31:0] == 32'd0)) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h k=%0d ctl=%b got res=%h ovf=%b zero=%b exp res=%h ovf=%b zero=%b",
               tag, a, b, k, c, result, ovf, zero, e[31:0], e[32], e[31:0] == 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got no end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; shamt = '0; ctl = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R10: idle inputs give all-zero result
    apply(32'd0, 32'd0, 5'd0, 8'd0, "R10");
    // R1: one operand pair through each class
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b00,1'b0,1'b0,2'b01,2'b00), "R1");
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b01,1'b0,1'b0,2'b01,2'b00), "R1");
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b10,1'b0,1'b0,2'b01,2'b00), "R1");
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b11,1'b0,1'b0,2'b01,2'b00), "R1");
    apply(32'd7, 32'd5, 5'd0, mk(2'b10,1'b0,1'b0,2'b00,2'b00), "R2");
    apply(32'hFFFF_FFFF, 32'd1, 5'd0, mk(2'b10,1'b0,1'b0,2'b00,2'b00), "R2");
    apply(32'd5, 32'd7, 5'd0, mk(2'b10,1'b1,1'b0,2'b00,2'b00), "R3");
    // R4: overflow both directions, then same operands in other classes
    apply(32'h7FFF_FFFF, 32'd1, 5'd0, mk(2'b10,1'b0,1'b0,2'b00,2'b00), "R4");
    apply(32'h8000_0000, 32'd1, 5'd0, mk(2'b10,1'b1,1'b0,2'b00,2'b00), "R4");
    apply(32'h7FFF_FFFF, 32'd1, 5'd0, mk(2'b11,1'b0,1'b0,2'b00,2'b01), "R4");
    apply(32'h8000_0000, 32'd1, 5'd0, mk(2'b01,1'b1,1'b0,2'b00,2'b00), "R4");
    for (int f = 0; f < 4; f++)
      apply(32'hF0F0_1234, 32'hFF00_5678, 5'd0, mk(2'b11,1'b0,1'b0,2'b00,2'(f)), "R5");
    apply(32'd0, 32'hDEAD_BEEF, 5'd9, mk(2'b00,1'b0,1'b0,2'b00,2'b00), "R6");
    apply(32'd0, 32'h8000_0001, 5'd4, mk(2'b00,1'b0,1'b0,2'b01,2'b00), "R6");
    apply(32'd0, 32'h8000_0001, 5'd31, mk(2'b00,1'b0,1'b0,2'b10,2'b00), "R6");
    apply(32'd0, 32'h8000_0000, 5'd31, mk(2'b00,1'b0,1'b0,2'b11,2'b00), "R7");
    apply(32'd0, 32'h7FFF_FFFF, 5'd31, mk(2'b00,1'b0,1'b0,2'b11,2'b00), "R7");
    apply(32'hFFFF_FFE3, 32'hF000_000F, 5'd17, mk(2'b00,1'b0,1'b1,2'b10,2'b00), "R8");
    apply(32'h0000_0003, 32'hF000_000F, 5'd17, mk(2'b00,1'b0,1'b1,2'b10,2'b00), "R8");
    apply(32'hFFFF_FFE3, 32'hF000_000F, 5'd1, mk(2'b00,1'b0,1'b0,2'b10,2'b00), "R8");
    apply(32'hFFFF_FFFF, 32'd1, 5'd0, mk(2'b01,1'b0,1'b0,2'b00,2'b00), "R9");
    apply(32'd1, 32'hFFFF_FFFF, 5'd0, mk(2'b01,1'b1,1'b0,2'b00,2'b00), "R9");
    apply(32'h8000_0000, 32'd1, 5'd0, mk(2'b01,1'b0,1'b0,2'b00,2'b00), "R9");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 5'd0, mk(2'b01,1'b0,1'b0,2'b00,2'b00), "R9");
    apply(32'd9, 32'd9, 5'd0, mk(2'b01,1'b0,1'b0,2'b00,2'b00), "R9");
    apply(32'h1234_5678, 32'h1234_5678, 5'd0, mk(2'b10,1'b1,1'b0,2'b00,2'b00), "R10");
    apply(32'hFFFF_0000, 32'h0000_FFFF, 5'd0, mk(2'b11,1'b0,1'b0,2'b00,2'b00), "R10");
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      logic [7:0]  rc;
      logic [4:0]  rk;
      ra = $urandom(); rb = $urandom(); rc = 8'($urandom()); rk = 5'($urandom());
      if (i % 8 == 0) ra = {1'b0, {31{ra[0]}}};
      if (i % 8 == 1) rb = {rb[0], 31'd0};
      apply(ra, rb, rk, rc, tag_of(rc));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule